// File: doc/BRIEF.md
# Divider configuration loader for a clock synthesizer

This block holds the settings that a frequency synthesizer's dividers run from: a 9-bit feedback divide value, a 2-bit output-divide code and a spread-spectrum enable. The settings arrive on one of two paths. The first is a 9-bit parallel bus with an active-low load strobe. While the strobe is low the bus value passes straight through, and when the strobe rises the value is kept. The second is a three-wire serial port made up of a serial clock, a serial data line and a load line. On this path a frame is shifted in and then committed, or, while the load line is held high, each bit passes straight to the dividers.

All pins are asynchronous to the system clock. The strobe, serial clock, load line and master reset each pass through a synchronizer. The parallel bus and serial data are delayed by the same number of stages, so each data bit is taken on the same system cycle that its edge is detected. The block also decodes the output-divide code into a divide ratio, flags feedback values that fall outside the lock window, and passes master reset on as a divider-clear level. The loop, the oscillator and the output drivers are not part of this block. Every pin is a plain level, with no valid/ready stream at the edge of the block, so no back-pressure rule applies.

Top module: `clkcfg_loader`

## Requirements
- R1: After rst_n is released, the outputs are m_val = DEF_M (200), n_code = 2'b01, div_ratio = 2, ssc_en = 0, m_oor = 0 and div_clr = 0.
- R2: While pl_strobe is low, m_val follows m_bus and n_code is forced to 2'b01. The parallel path leaves ssc_en unchanged.
- R3: When pl_strobe rises, the last m_bus value is kept. Later changes on m_bus have no effect on m_val until the strobe goes low again or a serial event occurs.
- R4: A serial frame is 14 bits long and is shifted in first to last. The first two bits are don't-care slots. They are followed by ssc_en, then n_code bit 1, then n_code bit 0, then m bits 8 down to 0, so m bit 0 is shifted last. Each bit is taken on a rising edge of s_clk. A rising edge on s_ld commits the most recent 12 bits to m_val, n_code and ssc_en.
- R5: While s_ld is low, shifting changes none of m_val, n_code or ssc_en. The values committed at the rise of s_ld stay frozen after it falls.
- R6: While s_ld is held high with pl_strobe high, each rising edge of s_clk copies the shifted m and n fields straight to m_val and n_code. ssc_en keeps the value it had at the rise of s_ld.
- R7: div_ratio is one-hot and decodes n_code as follows: 00 gives 1 (4'b0001), 01 gives 2, 10 gives 4, and 11 gives 8 (4'b1000).
- R8: m_oor is 1 exactly when m_val < M_LO (125) or m_val > M_HI (350). The boundary values 125 and 350 are in range.
- R9: div_clr follows mr after synchronization. mr does not change m_val, n_code or ssc_en.
- R10: Serial clock edges that arrive while pl_strobe is low do not shift the serial frame register. A later commit delivers the frame that was held before the parallel phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled in this domain |
| rst_n | input | 1 | Active-low synchronous reset to the power-up defaults |
| mr | input | 1 | Master reset request for the downstream dividers |
| pl_strobe | input | 1 | Parallel load strobe; low = transparent, rising = keep |
| m_bus | input | 9 | Parallel feedback divide value |
| s_clk | input | 1 | Serial shift clock |
| s_dat | input | 1 | Serial data |
| s_ld | input | 1 | Serial commit / pass-through control |
| m_val | output | 9 | Active feedback divide value |
| n_code | output | 2 | Active output-divide code |
| ssc_en | output | 1 | Spread-spectrum enable |
| div_ratio | output | 4 | One-hot decoded output divide ratio |
| m_oor | output | 1 | Feedback value outside the lock window |
| div_clr | output | 1 | Synchronized divider clear |

## Verification
The bench builds the block with its default parameters. These are a lock window of 125 to 350, a reset value of 200 and two synchronizer stages. With these values, short serial frames can reach the window edges 124, 125, 350 and 351, as well as the extreme codes 0 and 511. The reset value lies inside the window, so a flag raised wrongly at reset would be seen. Two synchronizer stages put every output change three system cycles after a pin edge. This lets the bench hold each serial level for four cycles and still sample settled values.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int M_W   = 9;
  localparam int N_W   = 2;
  localparam int CFG_W = 1 + N_W + M_W;
  localparam int RAT_W = 1 << N_W;

  typedef logic [M_W-1:0]   mval_t;
  typedef logic [N_W-1:0]   ncode_t;
  typedef logic [RAT_W-1:0] ratio_t;

  // Field order follows the shift order: the earliest bit kept is ssc.
  typedef struct packed {
    logic   ssc;
    ncode_t n;
    mval_t  m;
  } cfg_t;

  localparam ncode_t N_PAR = ncode_t'(1);

  // Edge-detected lanes come first.
  typedef enum int {LN_SCK = 0, LN_SLD = 1, LN_PL = 2, LN_MR = 3} lane_e;
  localparam int LANES = 4;
  localparam int EDGES = 2;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 4,
  parameter int EDGES  = 2,
  parameter logic [LANES-1:0] RST_VAL = '0,
  parameter int DW     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_in,
  input  logic [DW-1:0]    dat_in,
  output logic [LANES-1:0] lane_lvl,
  output logic [EDGES-1:0] lane_rise,
  output logic [DW-1:0]    dat_out
);
  logic [LANES-1:0] lstg [STAGES];
  logic [DW-1:0]    dstg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        lstg[k] <= RST_VAL;
        dstg[k] <= '0;
      end
    end else begin
      lstg[0] <= lane_in;
      dstg[0] <= dat_in;
      for (int k = 1; k < STAGES; k++) begin
        lstg[k] <= lstg[k-1];
        dstg[k] <= dstg[k-1];
      end
    end
  end

  assign lane_lvl = lstg[STAGES-1];
  assign dat_out  = dstg[STAGES-1];

  for (genvar g = 0; g < EDGES; g++) begin : g_edge
    logic prv;
    always_ff @(posedge clk) begin
      if (!rst_n) prv <= RST_VAL[g];
      else        prv <= lane_lvl[g];
    end
    assign lane_rise[g] = lane_lvl[g] & ~prv;
  end
endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter
  import clkcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  output cfg_t view
);
  // Only the newest CFG_W bits are kept; the don't-care slots fall off the top.
  logic [CFG_W-1:0] sr;
  logic [CFG_W-1:0] shifted;

  assign shifted = {sr[CFG_W-2:0], bit_in};
  assign view    = cfg_t'(shift_en ? shifted : sr);

  always_ff @(posedge clk) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= shifted;
  end
endmodule

// File: rtl/cfg_apply.sv
module cfg_apply
  import clkcfg_pkg::*;
#(
  parameter int M_LO  = 125,
  parameter int M_HI  = 350,
  parameter int DEF_M = 200
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   par_en,
  input  mval_t  m_par,
  input  logic   ser_load,
  input  logic   pass_en,
  input  cfg_t   view,
  output cfg_t   cur,
  output ratio_t ratio,
  output logic   oor
);
  localparam mval_t LO_V  = mval_t'(M_LO);
  localparam mval_t HI_V  = mval_t'(M_HI);
  localparam mval_t DEF_V = mval_t'(DEF_M);

  cfg_t nxt;

  // Parallel path wins; then commit; then pass-through.
  always_comb begin
    nxt = cur;
    if (par_en) begin
      nxt.m = m_par;
      nxt.n = N_PAR;
    end else if (ser_load) begin
      nxt = view;
    end else if (pass_en) begin
      nxt.m = view.m;
      nxt.n = view.n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '{ssc: 1'b0, n: N_PAR, m: DEF_V};
      ratio <= ratio_t'(1) << N_PAR;
      oor   <= (DEF_V < LO_V) || (DEF_V > HI_V);
    end else begin
      cur   <= nxt;
      ratio <= ratio_t'(1) << nxt.n;
      oor   <= (nxt.m < LO_V) || (nxt.m > HI_V);
    end
  end
endmodule

// File: rtl/clkcfg_loader.sv
module clkcfg_loader
  import clkcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_LO        = 125,
  parameter int M_HI        = 350,
  parameter int DEF_M       = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mr,
  input  logic         pl_strobe,
  input  logic [8:0]   m_bus,
  input  logic         s_clk,
  input  logic         s_dat,
  input  logic         s_ld,
  output logic [8:0]   m_val,
  output logic [1:0]   n_code,
  output logic         ssc_en,
  output logic [3:0]   div_ratio,
  output logic         m_oor,
  output logic         div_clr
);
  localparam int DW = M_W + 1;
  localparam logic [LANES-1:0] LANE_RST = LANES'(1) << LN_PL;

  logic [LANES-1:0] lane_in, lane_lvl;
  logic [EDGES-1:0] lane_rise;
  logic [DW-1:0]    dat_s;

  assign lane_in[LN_SCK] = s_clk;
  assign lane_in[LN_SLD] = s_ld;
  assign lane_in[LN_PL]  = pl_strobe;
  assign lane_in[LN_MR]  = mr;

  cfg_edge_sync #(
    .STAGES (SYNC_STAGES), .LANES(LANES), .EDGES(EDGES),
    .RST_VAL(LANE_RST), .DW(DW)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .dat_in({s_dat, m_bus}),
    .lane_lvl(lane_lvl), .lane_rise(lane_rise), .dat_out(dat_s)
  );

  logic pl_lvl, sld_lvl, sclk_rise, sld_rise;
  logic shift_en, ser_load, pass_en;
  assign pl_lvl    = lane_lvl[LN_PL];
  assign sld_lvl   = lane_lvl[LN_SLD];
  assign sclk_rise = lane_rise[LN_SCK];
  assign sld_rise  = lane_rise[LN_SLD];
  assign shift_en  = pl_lvl & sclk_rise;
  assign ser_load  = pl_lvl & sld_rise;
  assign pass_en   = shift_en & sld_lvl;

  cfg_t view, cur;
  ratio_t ratio;

  cfg_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .bit_in(dat_s[DW-1]), .view(view)
  );

  cfg_apply #(.M_LO(M_LO), .M_HI(M_HI), .DEF_M(DEF_M)) u_apply (
    .clk(clk), .rst_n(rst_n), .par_en(~pl_lvl), .m_par(dat_s[M_W-1:0]),
    .ser_load(ser_load), .pass_en(pass_en), .view(view),
    .cur(cur), .ratio(ratio), .oor(m_oor)
  );

  assign m_val     = cur.m;
  assign n_code    = cur.n;
  assign ssc_en    = cur.ssc;
  assign div_ratio = ratio;
  assign div_clr   = lane_lvl[LN_MR];
endmodule

// File: rtl/clkcfg_loader_chk.sv
module clkcfg_loader_chk #(
  parameter int M_LO = 125,
  parameter int M_HI = 350
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pl_lvl,
  input logic       sld_lvl,
  input logic       sclk_rise,
  input logic       sld_rise,
  input logic [8:0] m_val,
  input logic [1:0] n_code,
  input logic       ssc_en,
  input logic [3:0] div_ratio,
  input logic       m_oor
);
  assert_par_div2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pl_lvl) |-> n_code == 2'b01);

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_lvl && !sclk_rise && !sld_rise) |=> $stable(m_val));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_lvl && !sld_lvl) |=> ($stable(m_val) && $stable(n_code) && $stable(ssc_en)));

  assert_ssc_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_lvl && sld_lvl && !sld_rise) |=> $stable(ssc_en));

  assert_ratio_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_ratio) == 1 && div_ratio == (4'b0001 << n_code));

  assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_oor == ((int'(m_val) < M_LO) || (int'(m_val) > M_HI)));
endmodule

bind clkcfg_loader clkcfg_loader_chk #(.M_LO(M_LO), .M_HI(M_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .pl_lvl(pl_lvl), .sld_lvl(sld_lvl),
  .sclk_rise(sclk_rise), .sld_rise(sld_rise), .m_val(m_val),
  .n_code(n_code), .ssc_en(ssc_en), .div_ratio(div_ratio), .m_oor(m_oor)
);

// File: tb/clkcfg_loader_bench.sv
`timescale 1ns/1ps
module clkcfg_loader_bench;
  logic clk = 1'b0, rst_n = 1'b0, mr = 1'b0, pl_strobe = 1'b1;
  logic [8:0] m_bus = '0;
  logic s_clk = 1'b0, s_dat = 1'b0, s_ld = 1'b0;
  logic [8:0] m_val; logic [1:0] n_code; logic ssc_en;
  logic [3:0] div_ratio; logic m_oor, div_clr;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  clkcfg_loader u_clkcfg_loader (
    .clk(clk), .rst_n(rst_n), .mr(mr), .pl_strobe(pl_strobe), .m_bus(m_bus),
    .s_clk(s_clk), .s_dat(s_dat), .s_ld(s_ld), .m_val(m_val), .n_code(n_code),
    .ssc_en(ssc_en), .div_ratio(div_ratio), .m_oor(m_oor), .div_clr(div_clr)
  );

  // {frame[13:0] = nul2,ssc,n1,n0,m8..m0 ; expected ratio ; expected out-of-range}
  localparam logic [18:0] VEC [0:6] = '{
    {14'b11100011001000, 4'b0001, 1'b0},
    {14'b00001001111101, 4'b0010, 1'b0},
    {14'b00110001111100, 4'b0100, 1'b1},
    {14'b10011101011110, 4'b1000, 1'b0},
    {14'b01101101011111, 4'b0010, 1'b1},
    {14'b00010000000000, 4'b0100, 1'b1},
    {14'b00111111111111, 4'b1000, 1'b1}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    s_dat = b;  wait_cyc(4);
    s_clk = 1'b1; wait_cyc(4);
    s_clk = 1'b0; wait_cyc(4);
  endtask

  task automatic shift_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) sbit(f[i]);
  endtask

  task automatic commit();
    s_ld = 1'b1; wait_cyc(6);
    s_ld = 1'b0; wait_cyc(6);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 m_val", m_val, 200);
    chk("R1 n_code", n_code, 1);
    chk("R1 div_ratio", div_ratio, 2);
    chk("R1 ssc_en", ssc_en, 0);
    chk("R1 m_oor", m_oor, 0);
    chk("R1 div_clr", div_clr, 0);

    for (int v = 0; v < 7; v++) begin
      shift_frame(VEC[v][18:5]);
      commit();
      chk("R4 m field", m_val, VEC[v][13:5]);
      chk("R4 n field", n_code, VEC[v][15:14]);
      chk("R4 ssc field", ssc_en, VEC[v][16]);
      chk("R7 ratio", div_ratio, VEC[v][4:1]);
      chk("R8 window flag", m_oor, VEC[v][0]);
    end

    // Parallel path; ssc_en is 1 from the last frame.
    m_bus = 9'd300; pl_strobe = 1'b0; wait_cyc(6);
    chk("R2 m follows bus", m_val, 300);
    chk("R2 n forced", n_code, 1);
    chk("R2 ratio", div_ratio, 2);
    chk("R2 ssc untouched", ssc_en, 1);
    m_bus = 9'd130; wait_cyc(6);
    chk("R2 m follows change", m_val, 130);
    // R10: serial clocks while the strobe is low
    for (int i = 0; i < 14; i++) sbit(1'b0);
    chk("R10 parallel still active", m_val, 130);
    pl_strobe = 1'b1; wait_cyc(6);
    m_bus = 9'd77; wait_cyc(6);
    chk("R3 latched", m_val, 130);
    chk("R3 n kept", n_code, 1);
    commit();
    chk("R10 old frame m", m_val, 511);
    chk("R10 old frame n", n_code, 3);

    // R6: pass-through while s_ld high
    shift_frame(14'b00010011111010);
    commit();
    chk("R6 setup m", m_val, 250);
    s_ld = 1'b1; wait_cyc(6);
    chk("R6 commit ssc", ssc_en, 0);
    shift_frame(14'b00101101001101);
    chk("R6 pass m", m_val, 333);
    chk("R6 pass n", n_code, 1);
    chk("R6 ssc not passed", ssc_en, 0);
    sbit(1'b1);
    chk("R6 extra bit m", m_val, 155);
    chk("R6 extra bit n", n_code, 3);
    chk("R7 ratio after pass", div_ratio, 8);
    s_ld = 1'b0; wait_cyc(6);
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    chk("R5 frozen m", m_val, 155);
    chk("R5 frozen n", n_code, 3);
    chk("R5 frozen ssc", ssc_en, 0);

    mr = 1'b1; wait_cyc(6);
    chk("R9 div_clr high", div_clr, 1);
    chk("R9 m kept", m_val, 155);
    chk("R9 n kept", n_code, 3);
    mr = 1'b0; wait_cyc(6);
    chk("R9 div_clr low", div_clr, 0);
    chk("R9 m still kept", m_val, 155);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule